// File: doc/BRIEF.md
# Per-Core Locality Mode Classifier

This block sits beside the home directory entry of one cache line and decides, for every core, how that core is served: as a private sharer that receives the whole line into its L1, or as a remote sharer whose loads and stores are carried out one word at a time at the shared cache. Every core begins as a private sharer. The directory tells the classifier about each eviction or invalidation of a private copy, passing along the core's private reuse count. A low count moves that core to remote service.

While a core is remote, the classifier counts its accesses at the home. Once the count reaches that core's promotion limit, the core gets the full line again. A store by any other core clears the count, because it would have invalidated a private copy. The promotion limit starts at the private caching threshold. It doubles, up to a ceiling, each time the core is demoted after a capacity eviction, which makes promotion harder for lines that keep thrashing the L1. It returns to its starting value whenever an eviction report shows good private reuse.

Each home access strobe produces one registered response. The response gives the requester's mode after the access and whether the grant is a line fill or a single-word operation.

Top module: `loc_mode_classifier`

## Requirements
- R1: After reset every core is private, its remote count is 0 and its promotion limit equals PCT (default 4). The first access by any core is therefore answered with a line grant and private mode.
- R2: An access by a private core is answered with a line grant (resp_line=1) and resp_private=1. The core's mode does not change.
- R3: An eviction report for a private core with a reported reuse count below PCT makes that core remote and clears its remote count. Its next access is answered with a word grant (resp_line=0, resp_private=0).
- R4: An eviction report for a private core with a count at or above PCT keeps the core private and resets its promotion limit to PCT.
- R5: Each access by a remote core adds one to its remote count. If the new count is at or above the core's promotion limit, the core becomes private, its count clears and it receives a line grant. Otherwise it receives a word grant. Promotion leaves the limit unchanged.
- R6: A write access (acc_write=1) clears the remote count of every other remote core. The count of the writing core itself is updated under R2 or R5.
- R7: A demoting report with rpt_capacity=1 doubles the core's promotion limit, capped at PCT*RAT_MULT (default 64). A demoting report with rpt_capacity=0 leaves the limit unchanged.
- R8: An eviction report for a core that is already remote has no effect.
- R9: When a report and an access arrive in the same cycle, the report is applied first and the access sees the resulting state.
- R10: resp_valid is high exactly one cycle after each cycle with acc_valid high. In that cycle resp_core carries the requester, and resp_line equals resp_private.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Home-side access strobe |
| acc_core | input | CORE_W | Requesting core |
| acc_write | input | 1 | 1 = write access, 0 = read |
| rpt_valid | input | 1 | Eviction/invalidation report strobe |
| rpt_core | input | CORE_W | Core whose private copy left its L1 |
| rpt_util | input | UTIL_W | Private reuse count carried by the report |
| rpt_capacity | input | 1 | 1 = capacity eviction, 0 = invalidation |
| resp_valid | output | 1 | Response strobe |
| resp_core | output | CORE_W | Core the response belongs to |
| resp_private | output | 1 | 1 = requester now private, 0 = remote |
| resp_line | output | 1 | 1 = line fill grant, 0 = single-word grant |

## Verification
All state is updated on the edge that samples the strobes, and the response is registered. Each response therefore appears exactly one cycle after its access, and a report's effect is first visible in the response to the next access (or in the response to an access in the same cycle, per R9). The bench drives inputs on a falling edge and checks the response on the following falling edge, so every check lands on the one cycle its stimulus makes due. A bench model, written from the requirements, predicts mode and grant. Directed sequences cover demotion, promotion, limit doubling up to the cap, foreign-write clearing, ignored reports and same-cycle collisions.

// File: rtl/loc_class_pkg.sv
package loc_class_pkg;

    typedef enum logic {
        GRANT_WORD = 1'b0,
        GRANT_LINE = 1'b1
    } loc_grant_e;

endpackage

// File: rtl/loc_sat_inc.sv
module loc_sat_inc #(
    parameter int W    = 7,
    parameter int MAXV = 64
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] inc
);
    localparam logic [W-1:0] MAXV_V = W'(MAXV);

    always_comb begin
        if (val >= MAXV_V) inc = MAXV_V;
        else               inc = val + W'(1);
    end
endmodule

// File: rtl/loc_core_slot.sv
module loc_core_slot
    import loc_class_pkg::*;
#(
    parameter int PCT     = 4,
    parameter int RAT_MAX = 64,
    parameter int CNT_W   = 7,
    parameter int UTIL_W  = 3
) (
    input  logic              cur_remote,
    input  logic [CNT_W-1:0]  cur_rutil,
    input  logic [CNT_W-1:0]  cur_rat,
    input  logic              rpt_hit,
    input  logic [UTIL_W-1:0] rpt_util,
    input  logic              rpt_capacity,
    input  logic              acc_hit,
    input  logic              foreign_write,
    output logic              nxt_remote,
    output logic [CNT_W-1:0]  nxt_rutil,
    output logic [CNT_W-1:0]  nxt_rat,
    output loc_grant_e        grant
);
    localparam logic [CNT_W-1:0] RAT_INIT = CNT_W'(PCT);
    localparam logic [CNT_W-1:0] RAT_CAP  = CNT_W'(RAT_MAX);

    logic             ev_remote;
    logic [CNT_W-1:0] ev_rutil;
    logic [CNT_W-1:0] ev_rat;
    logic [CNT_W-1:0] rat_dbl;
    logic [CNT_W-1:0] rutil_inc;

    loc_sat_inc #(.W(CNT_W), .MAXV(RAT_MAX)) u_inc (
        .val (ev_rutil),
        .inc (rutil_inc)
    );

    always_comb begin
        if (int'(cur_rat) * 2 > RAT_MAX) rat_dbl = RAT_CAP;
        else                             rat_dbl = cur_rat << 1;
    end

    // report stage: applied before any same-cycle access
    always_comb begin
        ev_remote = cur_remote;
        ev_rutil  = cur_rutil;
        ev_rat    = cur_rat;
        if (rpt_hit && !cur_remote) begin
            if (int'(rpt_util) < PCT) begin
                ev_remote = 1'b1;
                ev_rutil  = '0;
                if (rpt_capacity) ev_rat = rat_dbl;
            end else begin
                ev_rat = RAT_INIT;
            end
        end
    end

    // access stage
    always_comb begin
        nxt_remote = ev_remote;
        nxt_rutil  = ev_rutil;
        nxt_rat    = ev_rat;
        grant      = GRANT_LINE;
        if (acc_hit && ev_remote) begin
            if (rutil_inc >= ev_rat) begin
                nxt_remote = 1'b0;
                nxt_rutil  = '0;
                grant      = GRANT_LINE;
            end else begin
                nxt_rutil  = rutil_inc;
                grant      = GRANT_WORD;
            end
        end
        if (foreign_write && nxt_remote) nxt_rutil = '0;
    end
endmodule

// File: rtl/loc_mode_classifier.sv
module loc_mode_classifier
    import loc_class_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int PCT       = 4,
    parameter int RAT_MULT  = 16,
    parameter int UTIL_W    = 3,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [CORE_W-1:0] acc_core,
    input  logic              acc_write,
    input  logic              rpt_valid,
    input  logic [CORE_W-1:0] rpt_core,
    input  logic [UTIL_W-1:0] rpt_util,
    input  logic              rpt_capacity,
    output logic              resp_valid,
    output logic [CORE_W-1:0] resp_core,
    output logic              resp_private,
    output logic              resp_line
);
    localparam int RAT_MAX = PCT * RAT_MULT;
    localparam int CNT_W   = $clog2(RAT_MAX + 1);
    localparam logic [CNT_W-1:0] RAT_INIT = CNT_W'(PCT);

    typedef struct packed {
        logic [NUM_CORES-1:0]            remote;
        logic [NUM_CORES-1:0][CNT_W-1:0] rutil;
        logic [NUM_CORES-1:0][CNT_W-1:0] rat;
        logic                            resp_valid;
        logic [CORE_W-1:0]               resp_core;
        logic                            resp_private;
        logic                            resp_line;
    } state_t;

    state_t st_d, st_q;

    logic             nxt_remote [NUM_CORES];
    logic [CNT_W-1:0] nxt_rutil  [NUM_CORES];
    logic [CNT_W-1:0] nxt_rat    [NUM_CORES];
    loc_grant_e       grant      [NUM_CORES];

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        loc_core_slot #(
            .PCT     (PCT),
            .RAT_MAX (RAT_MAX),
            .CNT_W   (CNT_W),
            .UTIL_W  (UTIL_W)
        ) u_slot (
            .cur_remote    (st_q.remote[i]),
            .cur_rutil     (st_q.rutil[i]),
            .cur_rat       (st_q.rat[i]),
            .rpt_hit       (rpt_valid && (rpt_core == CORE_W'(i))),
            .rpt_util      (rpt_util),
            .rpt_capacity  (rpt_capacity),
            .acc_hit       (acc_valid && (acc_core == CORE_W'(i))),
            .foreign_write (acc_valid && acc_write && (acc_core != CORE_W'(i))),
            .nxt_remote    (nxt_remote[i]),
            .nxt_rutil     (nxt_rutil[i]),
            .nxt_rat       (nxt_rat[i]),
            .grant         (grant[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CORES; i++) begin
            st_d.remote[i] = nxt_remote[i];
            st_d.rutil[i]  = nxt_rutil[i];
            st_d.rat[i]    = nxt_rat[i];
        end
        st_d.resp_valid   = acc_valid;
        st_d.resp_core    = acc_core;
        st_d.resp_private = 1'b1;
        st_d.resp_line    = 1'b1;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (acc_core == CORE_W'(i)) begin
                st_d.resp_private = !nxt_remote[i];
                st_d.resp_line    = (grant[i] == GRANT_LINE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.remote       <= '0;
            st_q.rutil        <= '0;
            for (int i = 0; i < NUM_CORES; i++) st_q.rat[i] <= RAT_INIT;
            st_q.resp_valid   <= 1'b0;
            st_q.resp_core    <= '0;
            st_q.resp_private <= 1'b1;
            st_q.resp_line    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid   = st_q.resp_valid;
    assign resp_core    = st_q.resp_core;
    assign resp_private = st_q.resp_private;
    assign resp_line    = st_q.resp_line;
endmodule

// File: rtl/loc_mode_classifier_chk.sv
module loc_mode_classifier_chk #(
    parameter int CORE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [CORE_W-1:0] acc_core,
    input logic              resp_valid,
    input logic [CORE_W-1:0] resp_core,
    input logic              resp_private,
    input logic              resp_line
);
    AST_RESP_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid); // R10
    AST_NO_RESP_WITHOUT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid); // R10
    AST_RESP_CORE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (resp_core == $past(acc_core))); // R10
    AST_LINE_IFF_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_line == resp_private)); // R2
endmodule

bind loc_mode_classifier loc_mode_classifier_chk #(.CORE_W(CORE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_core     (acc_core),
    .resp_valid   (resp_valid),
    .resp_core    (resp_core),
    .resp_private (resp_private),
    .resp_line    (resp_line)
);

// File: tb/loc_mode_classifier_tb.sv
module loc_mode_classifier_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CORES  = 4;
    localparam int PCT        = 4;
    localparam int RAT_MULT   = 16;
    localparam int UTIL_W     = 3;
    localparam int CORE_W     = 2;
    localparam int RAT_MAX    = PCT * RAT_MULT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [CORE_W-1:0] acc_core = '0;
    logic              acc_write = 1'b0;
    logic              rpt_valid = 1'b0;
    logic [CORE_W-1:0] rpt_core = '0;
    logic [UTIL_W-1:0] rpt_util = '0;
    logic              rpt_capacity = 1'b0;
    logic              resp_valid;
    logic [CORE_W-1:0] resp_core;
    logic              resp_private;
    logic              resp_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit m_rem [NUM_CORES];
    int m_cnt [NUM_CORES];
    int m_rat [NUM_CORES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    loc_mode_classifier #(
        .NUM_CORES (NUM_CORES),
        .PCT       (PCT),
        .RAT_MULT  (RAT_MULT),
        .UTIL_W    (UTIL_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_core     (acc_core),
        .acc_write    (acc_write),
        .rpt_valid    (rpt_valid),
        .rpt_core     (rpt_core),
        .rpt_util     (rpt_util),
        .rpt_capacity (rpt_capacity),
        .resp_valid   (resp_valid),
        .resp_core    (resp_core),
        .resp_private (resp_private),
        .resp_line    (resp_line)
    );

    // expected behaviour from the requirements: report first (R9), then access
    task automatic model(input bit av, input int ac, input bit aw, input bit rv,
                         input int rc, input int ru, input bit cap,
                         output bit ep, output bit el);
        if (rv && !m_rem[rc]) begin                    // R8: remote cores ignore reports
            if (ru < PCT) begin                        // R3
                m_rem[rc] = 1'b1;
                m_cnt[rc] = 0;
                if (cap) m_rat[rc] = (m_rat[rc] * 2 > RAT_MAX) ? RAT_MAX : m_rat[rc] * 2; // R7
            end else begin
                m_rat[rc] = PCT;                       // R4
            end
        end
        ep = 1'b1;
        el = 1'b1;
        if (av) begin
            if (m_rem[ac]) begin                       // R5
                if (m_cnt[ac] + 1 >= m_rat[ac]) begin
                    m_rem[ac] = 1'b0;
                    m_cnt[ac] = 0;
                end else begin
                    m_cnt[ac] = m_cnt[ac] + 1;
                    ep = 1'b0;
                    el = 1'b0;
                end
            end
            if (aw) begin                              // R6
                for (int k = 0; k < NUM_CORES; k++)
                    if (k != ac && m_rem[k]) m_cnt[k] = 0;
            end
        end
    endtask

    // called at a falling edge; checks the response on the next falling edge
    task automatic step(input bit av, input int ac, input bit aw, input bit rv,
                        input int rc, input int ru, input bit cap, input string req);
        bit ep, el;
        acc_valid    = av;
        acc_core     = CORE_W'(ac);
        acc_write    = aw;
        rpt_valid    = rv;
        rpt_core     = CORE_W'(rc);
        rpt_util     = UTIL_W'(ru);
        rpt_capacity = cap;
        model(av, ac, aw, rv, rc, ru, cap, ep, el);
        @(negedge clk);
        n_checks++;
        if (resp_valid !== av ||
            (av && (resp_core !== CORE_W'(ac) || resp_private !== ep || resp_line !== el))) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b core=%0d private=%0b line=%0b, expected valid=%0b core=%0d private=%0b line=%0b",
                     req, resp_valid, resp_core, resp_private, resp_line, av, ac, ep, el);
        end
        acc_valid = 1'b0;
        acc_write = 1'b0;
        rpt_valid = 1'b0;
    endtask

    task automatic access(input int c, input bit w, input string req);
        step(1'b1, c, w, 1'b0, 0, 0, 1'b0, req);
    endtask

    task automatic report(input int c, input int u, input bit cap, input string req);
        step(1'b0, 0, 1'b0, 1'b1, c, u, cap, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int k = 0; k < NUM_CORES; k++) begin
            m_rem[k] = 1'b0;
            m_cnt[k] = 0;
            m_rat[k] = PCT;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (resp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got resp_valid=%0b, expected 0 after reset", resp_valid);
        end

        // R1 / R2: all cores start private
        for (int c = 0; c < NUM_CORES; c++) access(c, 1'b0, "R1");
        access(0, 1'b1, "R2");

        // R3 demotion, then R5 promotion after PCT remote accesses
        report(0, 3, 1'b0, "R3");
        access(0, 1'b0, "R3");
        for (int i = 0; i < 3; i++) access(0, 1'b0, "R5");
        access(0, 1'b0, "R5");

        // R7: capacity demotions double the limit up to the cap
        for (int r = 0; r < 5; r++) begin
            report(1, r % 4, 1'b1, "R7");
            for (int i = 0; i < RAT_MAX; i++) begin
                if (m_rem[1]) access(1, 1'b0, "R7");
            end
        end
        // R4: good reuse resets the limit
        report(1, 6, 1'b0, "R4");
        report(1, 2, 1'b0, "R4");
        for (int i = 0; i < 4; i++) access(1, 1'b0, "R4");

        // R6: a foreign write clears the count, the core's own write counts
        report(2, 1, 1'b0, "R6");
        access(2, 1'b0, "R6");
        access(2, 1'b0, "R6");
        access(3, 1'b1, "R6");
        for (int i = 0; i < 4; i++) access(2, 1'b0, "R6");
        report(2, 0, 1'b0, "R6");
        for (int i = 0; i < 4; i++) access(2, 1'b1, "R6");

        // R8: a report for a remote core is ignored
        report(0, 1, 1'b0, "R8");
        access(0, 1'b0, "R8");
        report(0, 7, 1'b0, "R8");
        for (int i = 0; i < 3; i++) access(0, 1'b0, "R8");

        // R9: same-cycle report and access
        step(1'b1, 3, 1'b0, 1'b1, 3, 0, 1'b0, "R9");
        step(1'b1, 1, 1'b0, 1'b1, 3, 2, 1'b1, "R9");

        // random mix, R10 timing checked on every step
        seed = $urandom(1234);
        for (int i = 0; i < 3000; i++) begin
            int rv_r, av_r;
            av_r = ($urandom % 10) < 7 ? 1 : 0;
            rv_r = ($urandom % 10) < 2 ? 1 : 0;
            step(av_r[0], int'($urandom % NUM_CORES), ($urandom % 10) < 3,
                 rv_r[0], int'($urandom % NUM_CORES), int'($urandom % 8),
                 ($urandom % 2) == 1, "R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule